// File: doc/BRIEF.md
# BCD Calendar Clock Counter Chain

This block keeps wall-clock time and calendar date as packed BCD bytes. A single-cycle enable arrives at 32.768 kHz. A prescaler counts those enables down to one advance per second. Each advance steps a cascade of fields: seconds, minutes, hours in 24-hour form, weekday, day of month, month, two-digit year and century. Month lengths and February in leap years are handled without host help.

All eight fields come out as parallel ports. A one-cycle strobe marks every applied advance. The counters run on their own, so sampling the outputs never stalls the count and no second is lost. A synchronous load port lets a host preset any single field. Loading the seconds field also restarts the prescaler, so the next advance comes one full second after the load.

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the fields read 00:00:00, weekday 01, date 01, month 01, year 00, century 20, and `upd_o` is low.
- R2: Exactly one advance is applied after every `TICK_DIV` cycles with `tb_en_i` high. Cycles with the enable low do not count and change no field. `upd_o` is high for one cycle, in the same cycle that the new field values appear.
- R3: Seconds and minutes each go from 59 to 00, and each such wrap carries one into the next field up.
- R4: Hours go from 23 to 00, and that wrap advances both the date and the weekday.
- R5: Weekday counts 01 to 07 and returns to 01 on a day change.
- R6: Months 04, 06, 09 and 11 have 30 days and every other month except 02 has 31. Past the last day, the date returns to 01 and the month advances. Past month 12, the month returns to 01 and the year advances.
- R7: February has 29 days when the year value is divisible by four (00 included) and 28 days otherwise.
- R8: Year goes from 99 to 00 and adds one to the BCD century. Century goes from 99 to 00.
- R9: With `ld_en_i` high, `ld_val_i` is written on the next edge into the field chosen by `ld_sel_i`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. No other field changes.
- R10: A load with `ld_sel_i`=0 clears the prescaler, so the next advance needs a full `TICK_DIV` enables.
- R11: If a load and a prescaler tick fall in the same cycle, only the load takes effect: no field advances and `upd_o` stays low.
- R12: Loaded values are not checked. On the next advance, a field whose byte value is at or above its rollover limit (seconds 59, minutes 59, hours 23) wraps to its low value and carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tb_en_i | input | 1 | 32.768 kHz timebase enable, one cycle per period |
| ld_en_i | input | 1 | Field load strobe |
| ld_sel_i | input | 3 | Field selector for the load |
| ld_val_i | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hr_o | output | 8 | Hours 00-23, BCD |
| wday_o | output | 8 | Weekday 01-07, BCD |
| date_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month 01-12, BCD |
| yr_o | output | 8 | Year 00-99, BCD |
| cent_o | output | 8 | Century, BCD |
| upd_o | output | 1 | One-cycle strobe per applied advance |

## Verification
A host load and the prescaler's terminal tick can hit the same clock edge. The bench provokes this by giving `TICK_DIV`-1 enables and then raising the last enable in the same cycle as a minutes load. It then checks three things after that edge: `upd_o` is low, minutes hold the loaded value, and seconds are unchanged. A further full second then advances normally, which shows the prescaler stayed in phase.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HR   = 3'd2,
    F_WDAY = 3'd3,
    F_DATE = 3'd4,
    F_MON  = 3'd5,
    F_YR   = 3'd6,
    F_CENT = 3'd7
  } field_e;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  // Step a packed BCD byte by one; a units digit of 9 or more carries.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four: units mod 4 must be 0 for even tens, 2 for odd tens.
  function automatic logic leap_year(input logic [7:0] y);
    return y[1:0] == {y[4], 1'b0};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                            input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768,
  parameter int CW  = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  output logic          tick_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) cnt_q <= '0;
    else if (en_i)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_chain.sv
module cal_chain
  import cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       ld_en_i,
  input  logic [2:0] ld_sel_i,
  input  logic [7:0] ld_val_i,
  output cal_t       cal_o,
  output logic       upd_o,
  output logic       day_roll_o
);
  localparam cal_t RESET_CAL = '{cent: 8'h20, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                 wday: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  cal_t cur_q, nxt;
  logic w_sec, w_min, w_hr, w_date, w_mon, w_yr;
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cent;

  // Wrap flags: at or above the limit rolls over (covers loaded bad digits).
  assign w_sec  = cur_q.sec  >= 8'h59;
  assign w_min  = cur_q.min  >= 8'h59;
  assign w_hr   = cur_q.hr   >= 8'h23;
  assign w_date = cur_q.date >= month_last(cur_q.mon, cur_q.yr);
  assign w_mon  = cur_q.mon  >= 8'h12;
  assign w_yr   = cur_q.yr   >= 8'h99;

  assign c_min  = adv_i  && w_sec;
  assign c_hr   = c_min  && w_min;
  assign c_day  = c_hr   && w_hr;
  assign c_mon  = c_day  && w_date;
  assign c_yr   = c_mon  && w_mon;
  assign c_cent = c_yr   && w_yr;

  assign day_roll_o = c_day;

  always_comb begin
    nxt = cur_q;
    if (adv_i)  nxt.sec  = w_sec  ? 8'h00 : bcd_inc(cur_q.sec);
    if (c_min)  nxt.min  = w_min  ? 8'h00 : bcd_inc(cur_q.min);
    if (c_hr)   nxt.hr   = w_hr   ? 8'h00 : bcd_inc(cur_q.hr);
    if (c_day) begin
      nxt.wday = (cur_q.wday >= 8'h07) ? 8'h01 : bcd_inc(cur_q.wday);
      nxt.date = w_date ? 8'h01 : bcd_inc(cur_q.date);
    end
    if (c_mon)  nxt.mon  = w_mon  ? 8'h01 : bcd_inc(cur_q.mon);
    if (c_yr)   nxt.yr   = w_yr   ? 8'h00 : bcd_inc(cur_q.yr);
    if (c_cent) nxt.cent = (cur_q.cent >= 8'h99) ? 8'h00 : bcd_inc(cur_q.cent);
    if (ld_en_i) begin
      case (field_e'(ld_sel_i))
        F_SEC:   nxt.sec  = ld_val_i;
        F_MIN:   nxt.min  = ld_val_i;
        F_HR:    nxt.hr   = ld_val_i;
        F_WDAY:  nxt.wday = ld_val_i;
        F_DATE:  nxt.date = ld_val_i;
        F_MON:   nxt.mon  = ld_val_i;
        F_YR:    nxt.yr   = ld_val_i;
        default: nxt.cent = ld_val_i;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_q <= RESET_CAL;
      upd_o <= 1'b0;
    end else begin
      cur_q <= nxt;
      upd_o <= adv_i;
    end
  end

  assign cal_o = cur_q;
endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tb_en_i,
  input  logic       ld_en_i,
  input  logic [2:0] ld_sel_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic [7:0] cent_o,
  output logic       upd_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic          tick_w;
  logic          adv_w;
  logic          sec_ld_w;
  logic          day_roll_w;
  logic [CW-1:0] ps_cnt_w;
  cal_t          cal_w;

  assign sec_ld_w = ld_en_i && (ld_sel_i == F_SEC);
  assign adv_w    = tick_w && !ld_en_i;

  cal_prescaler #(.DIV(TICK_DIV), .CW(CW)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tb_en_i),
    .clr_i  (sec_ld_w),
    .tick_o (tick_w),
    .cnt_o  (ps_cnt_w)
  );

  cal_chain u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_w),
    .ld_en_i    (ld_en_i),
    .ld_sel_i   (ld_sel_i),
    .ld_val_i   (ld_val_i),
    .cal_o      (cal_w),
    .upd_o      (upd_o),
    .day_roll_o (day_roll_w)
  );

  assign sec_o  = cal_w.sec;
  assign min_o  = cal_w.min;
  assign hr_o   = cal_w.hr;
  assign wday_o = cal_w.wday;
  assign date_o = cal_w.date;
  assign mon_o  = cal_w.mon;
  assign yr_o   = cal_w.yr;
  assign cent_o = cal_w.cent;
endmodule

// File: rtl/cal_chain_checks.sv
module cal_chain_checks #(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          day_roll,
  input logic          ld_en,
  input logic [2:0]    ld_sel,
  input logic [CW-1:0] ps_cnt,
  input logic [7:0]    sec,
  input logic [7:0]    hr,
  input logic [7:0]    wday,
  input logic [7:0]    date,
  input logic          upd
);
  p_upd_follows_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_en) |=> upd);

  p_upd_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(tick && !ld_en));

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> ($stable(sec) && $stable(date) && $stable(hr)));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_en && sec >= 8'h59) |=> (sec == 8'h00));

  p_hour_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> (hr == 8'h00 && date != $past(date)));

  p_wday_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && wday >= 8'h01 && wday <= 8'h07) |=> (wday >= 8'h01 && wday <= 8'h07));

  p_sec_load_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 3'd0) |=> (ps_cnt == '0));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ld_en) |=> !upd);
endmodule

bind bcd_calendar_chain cal_chain_checks #(.CW(CW)) u_checks (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .tick     (tick_w),
  .day_roll (day_roll_w),
  .ld_en    (ld_en_i),
  .ld_sel   (ld_sel_i),
  .ps_cnt   (ps_cnt_w),
  .sec      (sec_o),
  .hr       (hr_o),
  .wday     (wday_o),
  .date     (date_o),
  .upd      (upd_o)
);

// File: tb/test_bcd_calendar_chain.sv
module test_bcd_calendar_chain;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_en = 1'b0, ld_en = 1'b0;
  logic [2:0] ld_sel = '0;
  logic [7:0] ld_val = '0;
  logic [7:0] sec, min, hr, wday, date, mon, yr, cent;
  logic upd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr, m_cent;

  always #2 clk = ~clk;

  bcd_calendar_chain #(.TICK_DIV(DIV)) i_bcd_calendar_chain (
    .clk_i(clk), .rst_ni(rst_n), .tb_en_i(tb_en), .ld_en_i(ld_en),
    .ld_sel_i(ld_sel), .ld_val_i(ld_val),
    .sec_o(sec), .min_o(min), .hr_o(hr), .wday_o(wday), .date_o(date),
    .mon_o(mon), .yr_o(yr), .cent_o(cent), .upd_o(upd)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "sec", sec, bcd(m_sec));   chk(req, "min", min, bcd(m_min));
    chk(req, "hr", hr, bcd(m_hr));      chk(req, "wday", wday, bcd(m_wd));
    chk(req, "date", date, bcd(m_date)); chk(req, "mon", mon, bcd(m_mon));
    chk(req, "yr", yr, bcd(m_yr));      chk(req, "cent", cent, bcd(m_cent));
  endtask

  task automatic model_step();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_date++;
    if (m_date <= days_in(m_mon, m_yr)) return;
    m_date = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr++;
    if (m_yr <= 99) return;
    m_yr = 0;
    m_cent = (m_cent == 99) ? 0 : m_cent + 1;
  endtask

  task automatic load(input int sel, input logic [7:0] v);
    @(negedge clk); ld_en = 1'b1; ld_sel = 3'(sel); ld_val = v;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic set_all(input int c, input int y, input int mo, input int d,
                         input int w, input int h, input int mi, input int s);
    load(7, bcd(c)); load(6, bcd(y)); load(5, bcd(mo)); load(4, bcd(d));
    load(3, bcd(w)); load(2, bcd(h)); load(1, bcd(mi)); load(0, bcd(s));
    m_cent = c; m_yr = y; m_mon = mo; m_date = d; m_wd = w;
    m_hr = h; m_min = mi; m_sec = s;
  endtask

  // One enable pulse followed by an idle gap cycle; ends at a negedge.
  task automatic pulse(input string req, input logic exp_upd);
    @(negedge clk); tb_en = 1'b1;
    @(negedge clk); tb_en = 1'b0;
    chk(req, "upd", {7'd0, upd}, {7'd0, exp_upd});
  endtask

  task automatic advance(input string req);
    for (int i = 0; i < DIV - 1; i++) pulse(req, 1'b0);
    pulse(req, 1'b1);
    model_step();
    chk_all(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    m_cent = 20; m_yr = 0; m_mon = 1; m_date = 1; m_wd = 1; m_hr = 0; m_min = 0; m_sec = 0;
    chk_all("R1");
    chk("R1", "upd", {7'd0, upd}, 8'd0);

    // R2: plain seconds, idle gaps do not count
    advance("R2");
    repeat (5) @(negedge clk);
    chk_all("R2");
    advance("R2");

    // R3: seconds and minute carries
    set_all(20, 24, 6, 15, 3, 10, 58, 59);
    advance("R3");
    advance("R3");

    // R4 R5 R6 R7: last day of every month over eight years
    for (int y = 0; y < 8; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_all(20, y, mo, days_in(mo, y), 1 + ((mo + y) % 7), 23, 59, 59);
        advance((mo == 2) ? "R7" : "R6");
      end
      set_all(20, y, 2, 28, 7, 23, 59, 59);
      advance("R7");
      chk("R5", "wday wrap", wday, 8'h01);
    end

    // R8: year and century wraps
    set_all(20, 99, 12, 31, 4, 23, 59, 59);
    advance("R8");
    set_all(99, 99, 12, 31, 2, 23, 59, 59);
    advance("R8");

    // R9: single field load leaves the rest alone
    set_all(21, 45, 8, 17, 5, 13, 27, 9);
    load(4, 8'h22); m_date = 22;
    chk_all("R9");

    // R10: partial count then seconds load restarts the prescaler
    pulse("R10", 1'b0); pulse("R10", 1'b0);
    load(0, 8'h30); m_sec = 30;
    advance("R10");

    // R11: load coincides with the terminal tick
    for (int i = 0; i < DIV - 1; i++) pulse("R11", 1'b0);
    @(negedge clk); tb_en = 1'b1; ld_en = 1'b1; ld_sel = 3'd1; ld_val = 8'h33;
    @(negedge clk); tb_en = 1'b0; ld_en = 1'b0;
    m_min = 33;
    chk("R11", "upd", {7'd0, upd}, 8'd0);
    chk_all("R11");
    advance("R11");

    // R12: out-of-range bytes roll over on the next advance
    set_all(20, 10, 3, 5, 2, 9, 14, 0);
    load(0, 8'h7B);
    advance_raw_check();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic advance_raw_check();
    for (int i = 0; i < DIV - 1; i++) pulse("R12", 1'b0);
    pulse("R12", 1'b1);
    chk("R12", "sec", sec, 8'h00);
    chk("R12", "min", min, 8'h15);
    load(2, 8'h2F); load(1, 8'h59); load(0, 8'h59);
    for (int i = 0; i < DIV - 1; i++) pulse("R12", 1'b0);
    pulse("R12", 1'b1);
    chk("R12", "hr", hr, 8'h00);
    chk("R12", "date", date, 8'h06);
  endtask
endmodule